// File: doc/BRIEF.md
# Memory Error Status and Interrupt Unit

This block records memory errors for one leaf of an ECC-protected memory controller. The controller sends it single-cycle event pulses for three error classes: a correctable read error, an uncorrectable read error and an uncorrectable partial-write error. Each pulse comes with the 40-bit address of the access. The unit keeps a sticky status bit for each class. It also sets a multiple-error flag when errors pile up, because the syndrome data is valid only while a single status bit is set. It keeps the address of the newest failing access.

Software reads the unit through a small select-based read port. It can take a plain snapshot of the status, or an atomic snapshot that clears the status in the same cycle. It can also read the captured address as a high byte and a low word, and read back the interrupt configuration. Two of the error classes, correctable read and uncorrectable partial write, raise a one-cycle interrupt request when interrupts are enabled. The request carries the priority and destination fields held in the configuration register at that moment.

Top module: `mem_err_unit`

## Requirements
- R1: A correctable read pulse sets status bit 2, an uncorrectable read pulse sets bit 1 and an uncorrectable partial-write pulse sets bit 0. A set bit stays set until a read-and-clear.
- R2: Status bit 3 (multiple error) is set when an error pulse arrives while any of bits 2:0 is already set. It is also set when two or more error pulses arrive in the same cycle.
- R3: Every error pulse captures its 40-bit address, so a later error overwrites an earlier one. Select 2 returns address bits 39:32 in rd_data[7:0] with the upper bits zero. Select 3 returns address bits 31:0.
- R4: Select 0 returns the 4-bit status in rd_data[3:0], with the upper bits zero, and leaves the status unchanged.
- R5: Select 1 returns the same word as select 0 and clears all four status bits. If an error pulse arrives in the same cycle as the clear, the status afterwards holds only the bits set by that pulse.
- R6: An interrupt is requested only for a correctable read error or an uncorrectable partial-write error, and only when bit 16 of the configuration register is set. An uncorrectable read error alone never requests one.
- R7: An interrupt request is a one-cycle pulse on irq_req, registered at the same clock edge that registers the error. It carries priority (configuration bits 15:8) and destination (bits 6:0) as held before any configuration write in the error's cycle.
- R8: The configuration register is 17 bits wide and resets to 0x13322. Bit 7 always reads zero. It is written through cfg_we and cfg_wdata and read back with select 4.
- R9: Read data and rd_valid appear one clock after rd_en is sampled. A select value of 5 to 7 returns zero.
- R10: After reset the status and the captured address are zero and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_corr_rd | input | 1 | Correctable read error pulse |
| ev_unc_rd | input | 1 | Uncorrectable read error pulse |
| ev_unc_pw | input | 1 | Uncorrectable partial-write error pulse |
| ev_addr | input | 40 | Address of the failing access |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 17 | Configuration write data |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Read select: 0 status, 1 status with clear, 2 address high, 3 address low, 4 configuration |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_req | output | 1 | Interrupt request pulse |
| irq_prio | output | 8 | Priority carried by the request |
| irq_dest | output | 7 | Destination carried by the request |

## Verification
An error pulse driven in cycle k shows up in the status and on irq_req at edge k+1. A read issued in cycle k returns its data at edge k+1, so a read can observe an error only if it is issued at least one cycle after that error. The driver applies every stimulus at the falling edge and updates a model of the requirements in that same cycle. It queues each expected read word, and each expected interrupt with the cycle number it is due in. The monitor samples at the next falling edge and compares each rd_valid word, and each irq_req pulse with its cycle, against the front of the matching queue. Expected interrupts that never arrive are counted as failures at the end.

// File: rtl/merr_pkg.sv
package merr_pkg;
  typedef enum logic [2:0] {
    SEL_STAT     = 3'd0,
    SEL_STAT_CLR = 3'd1,
    SEL_ADDR_HI  = 3'd2,
    SEL_ADDR_LO  = 3'd3,
    SEL_CFG      = 3'd4
  } rd_sel_e;

  localparam int ST_W     = 4;
  localparam int ST_MULTI = 3;
  localparam int ST_CORR  = 2;
  localparam int ST_UNC   = 1;
  localparam int ST_PW    = 0;
endpackage

// File: rtl/merr_status.sv
module merr_status
  import merr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      ev,      // {corr_rd, unc_rd, unc_pw}
  input  logic            clr,
  output logic [ST_W-1:0] stat
);
  logic [ST_W-1:0] base;
  logic [ST_W-1:0] nxt;
  logic            any_ev;
  logic            many_ev;
  logic            multi_new;

  always_comb begin
    base      = clr ? '0 : stat;
    any_ev    = |ev;
    many_ev   = (ev & (ev - 3'd1)) != 3'd0;
    multi_new = any_ev && ((|base[ST_CORR:ST_PW]) || many_ev);
    nxt       = base | {multi_new, ev};
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= nxt;
  end

  // R1: without a clear, no status bit ever falls
  a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((stat & $past(stat)) == $past(stat)));
  // R2: a new error on top of a pending one flags a multiple error
  a_r2_multi: assert property (@(posedge clk) disable iff (rst)
    (!clr && (|ev) && (|stat[ST_CORR:ST_PW])) |=> stat[ST_MULTI]);
  // R5: a clear with no event leaves all bits at zero
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|ev)) |=> (stat == '0));
endmodule

// File: rtl/merr_addr_cap.sv
module merr_addr_cap #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (cap) addr_q <= addr_in;
  end

  // R3: the newest error address is always the one held
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    cap |=> (addr_q == $past(addr_in)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(addr_q));
endmodule

// File: rtl/merr_irq.sv
module merr_irq #(
  parameter int PRIO_W  = 8,
  parameter int DEST_W  = 7,
  parameter int CFG_W   = 1 + PRIO_W + 1 + DEST_W,
  parameter logic [CFG_W-1:0] CFG_RST = 17'h13322
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wd,
  input  logic              trig,
  input  logic              no_trig_ev,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_prio,
  output logic [DEST_W-1:0] irq_dest
);
  localparam int EN_BIT  = CFG_W - 1;
  localparam int PAD_BIT = DEST_W;
  localparam int PRIO_LO = DEST_W + 1;

  logic [CFG_W-1:0] wmask;
  always_comb begin
    wmask          = '1;
    wmask[PAD_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RST & wmask;
    else if (cfg_we) cfg_q <= cfg_wd & wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_prio <= '0;
      irq_dest <= '0;
    end else if (trig && cfg_q[EN_BIT]) begin
      irq_req  <= 1'b1;
      irq_prio <= cfg_q[EN_BIT-1:PRIO_LO];
      irq_dest <= cfg_q[DEST_W-1:0];
    end else begin
      irq_req  <= 1'b0;
      irq_prio <= '0;
      irq_dest <= '0;
    end
  end

  // R6: a request needs an enabled qualifying error one cycle before
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(trig && cfg_q[EN_BIT]));
  a_r6_unc_rd_silent: assert property (@(posedge clk) disable iff (rst)
    (no_trig_ev && !trig) |=> !irq_req);
  // R8: the pad bit never holds a one
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[PAD_BIT]);
endmodule

// File: rtl/mem_err_unit.sv
module mem_err_unit
  import merr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 8,
  parameter int DEST_W = 7,
  parameter int CFG_W  = 1 + PRIO_W + 1 + DEST_W,
  parameter logic [CFG_W-1:0] CFG_RST = 17'h13322
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_corr_rd,
  input  logic              ev_unc_rd,
  input  logic              ev_unc_pw,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_en,
  input  logic [2:0]        rd_sel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_prio,
  output logic [DEST_W-1:0] irq_dest
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ST_W-1:0]   stat;
  logic [ADDR_W-1:0] addr_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [2:0]        ev;
  logic              clr;
  logic [DATA_W-1:0] rd_mux;

  assign ev  = {ev_corr_rd, ev_unc_rd, ev_unc_pw};
  assign clr = rd_en && (rd_sel == SEL_STAT_CLR);

  merr_status u_status (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .stat(stat)
  );

  merr_addr_cap #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .cap(|ev), .addr_in(ev_addr), .addr_q(addr_q)
  );

  merr_irq #(
    .PRIO_W(PRIO_W), .DEST_W(DEST_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)
  ) u_irq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wd(cfg_wdata),
    .trig(ev_corr_rd | ev_unc_pw), .no_trig_ev(ev_unc_rd),
    .cfg_q(cfg_q), .irq_req(irq_req), .irq_prio(irq_prio),
    .irq_dest(irq_dest)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_sel)
      SEL_STAT, SEL_STAT_CLR: rd_mux[ST_W-1:0]  = stat;
      SEL_ADDR_HI:            rd_mux[HI_W-1:0]  = addr_q[ADDR_W-1:DATA_W];
      SEL_ADDR_LO:            rd_mux            = addr_q[DATA_W-1:0];
      SEL_CFG:                rd_mux[CFG_W-1:0] = cfg_q;
      default:                rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  // R9: read data follows a request by exactly one cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/test_mem_err_unit.sv
`timescale 1ns/1ps
module test_mem_err_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_corr_rd = 0, ev_unc_rd = 0, ev_unc_pw = 0;
  logic [39:0] ev_addr = '0;
  logic        cfg_we = 0;
  logic [16:0] cfg_wdata = '0;
  logic        rd_en = 0;
  logic [2:0]  rd_sel = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [7:0]  irq_prio;
  logic [6:0]  irq_dest;

  always #2.5 clk = ~clk;

  mem_err_unit i_mem_err_unit (
    .clk(clk), .rst(rst), .ev_corr_rd(ev_corr_rd), .ev_unc_rd(ev_unc_rd),
    .ev_unc_pw(ev_unc_pw), .ev_addr(ev_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_req(irq_req),
    .irq_prio(irq_prio), .irq_dest(irq_dest)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [31:0] rq[$];
  string       rtag[$];
  logic [14:0] iq[$];
  int          icyc[$];

  logic [3:0]  m_stat = '0;
  logic [39:0] m_addr = '0;
  logic [16:0] m_cfg  = 17'h13322;

  always @(posedge clk) cyc <= cyc + 1;

  // driver: one cycle of stimulus, model update and expectation push
  task automatic drive(input logic c, input logic u, input logic p,
                       input logic [39:0] a, input logic re,
                       input logic [2:0] s, input logic cw,
                       input logic [16:0] cd, input string tag);
    logic [3:0]  base;
    logic [31:0] exp_rd;
    int          n;
    ev_corr_rd = c; ev_unc_rd = u; ev_unc_pw = p; ev_addr = a;
    rd_en = re; rd_sel = s; cfg_we = cw; cfg_wdata = cd;
    if (re) begin
      case (s)
        3'd0, 3'd1: exp_rd = {28'd0, m_stat};
        3'd2:       exp_rd = {24'd0, m_addr[39:32]};
        3'd3:       exp_rd = m_addr[31:0];
        3'd4:       exp_rd = {15'd0, m_cfg};
        default:    exp_rd = '0;
      endcase
      rq.push_back(exp_rd);
      rtag.push_back(tag);
    end
    if ((c || p) && m_cfg[16]) begin
      iq.push_back({m_cfg[15:8], m_cfg[6:0]});
      icyc.push_back(cyc + 1);
    end
    base = (re && s == 3'd1) ? 4'd0 : m_stat;
    n = int'(c) + int'(u) + int'(p);
    if (n > 0) begin
      m_stat = base | {((|base[2:0]) || n > 1), c, u, p};
      m_addr = a;
    end else m_stat = base;
    if (cw) m_cfg = cd & 17'h1FF7F;
    @(negedge clk);
    ev_corr_rd = 0; ev_unc_rd = 0; ev_unc_pw = 0;
    rd_en = 0; cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, input string tag);
    drive(0, 0, 0, '0, 1, s, 0, '0, tag);
  endtask

  task automatic err(input logic c, input logic u, input logic p,
                     input logic [39:0] a);
    drive(c, u, p, a, 0, 3'd0, 0, '0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_valid) begin
        checks++;
        if (rq.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected read data %h, expected none", rd_data);
        end else begin
          logic [31:0] e;
          string t;
          e = rq.pop_front();
          t = rtag.pop_front();
          if (rd_data !== e) begin
            fails++;
            $display("FAIL %s: rd_data %h, expected %h", t, rd_data, e);
          end
        end
      end
      if (irq_req) begin
        checks++;
        if (iq.size() == 0) begin
          fails++;
          $display("FAIL R6: irq at cycle %0d, expected none", cyc);
        end else begin
          logic [14:0] e;
          int ec;
          e  = iq.pop_front();
          ec = icyc.pop_front();
          if ({irq_prio, irq_dest} !== e || cyc != ec) begin
            fails++;
            $display("FAIL R7: irq %h at %0d, expected %h at %0d",
                     {irq_prio, irq_dest}, cyc, e, ec);
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    checks++;
    if (iq.size() != 0 || rq.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d irq / %0d reads outstanding, expected 0",
               iq.size(), rq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if (irq_req !== 1'b0) begin
      fails++;
      $display("FAIL R10: irq_req %b, expected 0", irq_req);
    end
    // R10 reset state, R8 reset configuration
    rd(3'd0, "R10");
    rd(3'd2, "R10");
    rd(3'd3, "R10");
    rd(3'd4, "R8");
    // R1 correctable read, R6/R7 irq with reset fields
    err(1, 0, 0, 40'hA5_1234_5678);
    rd(3'd0, "R1");
    rd(3'd0, "R4");
    rd(3'd2, "R3");
    rd(3'd3, "R3");
    // R5 read-and-clear
    rd(3'd1, "R5");
    rd(3'd0, "R5");
    // R6 uncorrectable read gives no irq, then R2 multiple error
    err(0, 1, 0, 40'h01_0000_0040);
    rd(3'd0, "R1");
    err(0, 0, 1, 40'h7F_DEAD_BEEF);
    rd(3'd0, "R2");
    rd(3'd2, "R3");
    rd(3'd3, "R3");
    rd(3'd1, "R5");
    // R2 simultaneous errors
    err(1, 1, 0, 40'h02_0000_1000);
    rd(3'd1, "R2");
    // R5 clear coincides with an event
    err(1, 0, 0, 40'h03_0000_2000);
    drive(0, 0, 1, 40'h04_0000_3000, 1, 3'd1, 0, '0, "R5");
    rd(3'd0, "R5");
    rd(3'd3, "R3");
    // R8 write with pad bit set, R6 disabled
    drive(0, 0, 0, '0, 0, 3'd0, 1, 17'h0_0080, "");
    rd(3'd4, "R8");
    err(1, 0, 0, 40'h05_0000_0001);
    err(0, 0, 1, 40'h05_0000_0002);
    drive(0, 0, 0, '0, 0, 3'd0, 1, 17'h1_5AFF, "");
    rd(3'd4, "R8");
    // R7 fields from the new configuration; write in same cycle uses old
    err(1, 0, 0, 40'h06_0000_0003);
    drive(0, 0, 1, 40'h06_0000_0004, 0, 3'd0, 1, 17'h1_0102, "");
    err(1, 0, 0, 40'h06_0000_0005);
    // R9 unused selects
    rd(3'd5, "R9");
    rd(3'd7, "R9");
    rd(3'd0, "R1");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule